// File: doc/BRIEF.md
# Interrupt Controller with Register Bus

This block gathers up to 32 interrupt sources into a single request line for a processor. The build fixes how each input is captured. A source can latch on a rising edge, or it can follow a level for as long as that level is held. Captured requests sit in a status register until software clears them. An enable register selects which captured requests count as pending. A vector register reports the number of the lowest-numbered pending source, so the handler does not have to scan a bitmask. A two-bit master control gates the request line.

Software reaches the block over a plain 32-bit register bus with an address, a write strobe, write data and read data. A read returns data in the same cycle, from the address alone. A write takes effect at the next clock edge. Three registers are write-one-to-act:

- The acknowledge register clears status bits.
- The enable-set register raises enable bits.
- The enable-clear register drops enable bits.

These let separate handlers change their own bits without a read-modify-write sequence. Sources are assumed to be synchronous to the block clock.

Top module: `intr_ctrl`

## Requirements
- R1: After reset the status, enable and master control registers read zero, `irq_req` is low, and the vector register reads 0xFFFFFFFF.
- R2: A source whose bit in `EDGE_KIND` is 1 sets its status bit on the clock where it is high and was low at the previous edge. The bit stays set after the source falls.
- R3: A source whose bit in `EDGE_KIND` is 0 sets its status bit at every clock where it is high. If it is still high, the bit is set again at the edge after the acknowledge that cleared it.
- R4: A write to byte offset 0x0C clears every status bit whose written bit is 1. If a capture falls on the same edge, the clear wins.
- R5: A write to offset 0x08 loads the whole enable register from the low `NUM_SRC` data bits. Enable bits at or above `NUM_SRC` always read 0.
- R6: A write to offset 0x10 sets each enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R7: A write to offset 0x14 clears each enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R8: Offset 0x00 reads the status register, offset 0x04 reads status AND enable, and offset 0x08 reads the enable register.
- R9: Offset 0x18 reads the index of the lowest-numbered pending source, zero-extended, or 0xFFFFFFFF when nothing is pending. It does not depend on the master control.
- R10: Offset 0x1C holds two bits. Bit 0 is the global enable and bit 1 is the hardware-request enable. `irq_req` is high exactly when both bits are 1 and at least one source is pending.
- R11: Writes to offsets 0x00, 0x04 and 0x18 change no state. Offsets 0x0C, 0x10 and 0x14 read as zero.
- R12: Read data depends only on the current address and register state, in the same cycle. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_in | input | NUM_SRC | Interrupt sources, synchronous to clk |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, acts at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is a level source that is still asserted when its acknowledge lands. A related case is an edge that arrives in the same cycle as an acknowledge of its bit. Either one needs a bus write and a source transition lined up on one exact clock. The directed stimulus therefore holds a level input high across an acknowledge and reads status in the next two cycles. It also raises an edge input in the cycle of the acknowledge write. A long phase of random source patterns and random register traffic then compares every output against a behavioural model on every clock.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;
  localparam int DATA_W = 32;

  // Word select taken from byte address bits [4:2]
  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/intr_capture.sv
module intr_capture #(
  parameter int          NUM_SRC   = 8,
  parameter logic [31:0] EDGE_KIND = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               ack_we,
  input  logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_KIND[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_in[i];
      end
      assign hit[i] = src_in[i] & ~prev_q;

      assert_edge_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_in[i] && !prev_q && !(ack_we && ack_mask[i])) |=> status_q[i]);
    end else begin : g_level
      assign hit[i] = src_in[i];

      assert_level_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_in[i] && !(ack_we && ack_mask[i])) |=> status_q[i]);
    end

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ack_mask[i]) |=> !status_q[i]);
  end

  // Capture first, then the acknowledge clear takes priority
  always_comb begin
    status_d = status_q | hit;
    if (ack_we) status_d = status_d & ~ack_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/intr_enable.sv
module intr_enable #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_we,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               en_ce;

  assign en_ce = load_we | set_we | clr_we;

  always_comb begin
    en_d = en_q;
    if (load_we)     en_d = wdata;
    else if (set_we) en_d = en_q | wdata;
    else if (clr_we) en_d = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_set_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && wdata[i]) |=> en_q[i]);
    assert_clr_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wdata[i]) |=> !en_q[i]);
    assert_set_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !wdata[i] && en_q[i]) |=> en_q[i]);
  end
endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // Scan from the top down so the lowest set index is the last one kept
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end

  assign found = |pend;
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_ctrl_pkg::*;
#(
  parameter int          NUM_SRC   = 8,
  parameter logic [31:0] EDGE_KIND = 32'h0000_00F0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [4:0]         bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_req
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e           sel;
  logic               ack_we, load_we, set_we, clr_we, mer_we;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] status, enable, pend;
  logic               found;
  logic [IDX_W-1:0]   idx;
  logic [1:0]         mer_q, mer_d;
  logic [DATA_W-1:0]  status_w, enable_w, pend_w, vector_w;

  assign sel     = reg_sel_e'(bus_addr[4:2]);
  assign wbits   = bus_wdata[NUM_SRC-1:0];
  assign ack_we  = bus_we && (sel == SEL_ACK);
  assign load_we = bus_we && (sel == SEL_ENABLE);
  assign set_we  = bus_we && (sel == SEL_SETEN);
  assign clr_we  = bus_we && (sel == SEL_CLREN);
  assign mer_we  = bus_we && (sel == SEL_MASTER);

  intr_capture #(.NUM_SRC(NUM_SRC), .EDGE_KIND(EDGE_KIND)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .ack_we   (ack_we),
    .ack_mask (wbits),
    .status_o (status)
  );

  intr_enable #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_we (load_we),
    .set_we  (set_we),
    .clr_we  (clr_we),
    .wdata   (wbits),
    .en_o    (enable)
  );

  assign pend = status & enable;

  intr_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend  (pend),
    .found (found),
    .idx   (idx)
  );

  // Master control: bit 0 global enable, bit 1 hardware request enable
  always_comb begin
    mer_d = mer_q;
    if (mer_we) mer_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mer_q <= 2'b00;
    else        mer_q <= mer_d;
  end

  assign irq_req = mer_q[0] & mer_q[1] & found;

  always_comb begin
    status_w = '0;
    enable_w = '0;
    pend_w   = '0;
    vector_w = '1;
    status_w[NUM_SRC-1:0] = status;
    enable_w[NUM_SRC-1:0] = enable;
    pend_w[NUM_SRC-1:0]   = pend;
    if (found) begin
      vector_w = '0;
      vector_w[IDX_W-1:0] = idx;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: bus_rdata = status_w;
      SEL_PEND:   bus_rdata = pend_w;
      SEL_ENABLE: bus_rdata = enable_w;
      SEL_VECTOR: bus_rdata = vector_w;
      SEL_MASTER: bus_rdata = {30'd0, mer_q};
      default:    bus_rdata = '0;
    endcase
  end

  assert_irq_needs_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (status != '0) && (enable != '0));
  assert_mer_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mer_we |=> (mer_q == $past(bus_wdata[1:0])));
  assert_vec_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (status[idx] && enable[idx]));
  assert_ro_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_VECTOR) |=> $stable(enable) && $stable(mer_q));
endmodule

// File: tb/intr_ctrl_bench.sv
`timescale 1ns/1ps
module intr_ctrl_bench;
  localparam int          N    = 8;
  localparam logic [31:0] KIND = 32'h0000_00F0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] src;
  logic [4:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  string cur_tag = "R1 reset";

  // Reference model state
  bit [N-1:0] m_st, m_en, m_prev;
  bit [1:0]   m_mer;

  always #2.5 clk = ~clk;

  intr_ctrl #(.NUM_SRC(N), .EDGE_KIND(KIND)) u_intr_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_addr(addr),
    .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_req(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= '0; m_en <= '0; m_prev <= '0; m_mer <= '0;
    end else begin
      bit [N-1:0] nst;
      bit [N-1:0] wb;
      wb = wdata[N-1:0];
      nst = m_st;
      for (int i = 0; i < N; i++) begin
        if (KIND[i]) begin
          if (src[i] && !m_prev[i]) nst[i] = 1'b1;
        end else if (src[i]) begin
          nst[i] = 1'b1;
        end
      end
      if (we) begin
        case (int'(addr) / 4)
          3: nst = nst & ~wb;
          2: m_en <= wb;
          4: m_en <= m_en | wb;
          5: m_en <= m_en & ~wb;
          7: m_mer <= wdata[1:0];
          default: ;
        endcase
      end
      m_st <= nst;
      m_prev <= src;
    end
  end

  function automatic bit [31:0] exp_rd();
    bit [N-1:0] p;
    bit [31:0] r;
    p = m_st & m_en;
    r = 0;
    case (int'(addr) / 4)
      0: r[N-1:0] = m_st;
      1: r[N-1:0] = p;
      2: r[N-1:0] = m_en;
      6: begin
        r = 32'hFFFF_FFFF;
        for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
      end
      7: r[1:0] = m_mer;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic bit exp_irq();
    return (m_mer == 2'b11) && ((m_st & m_en) != 0);
  endfunction

  task automatic compare();
    bit [31:0] er;
    bit ei;
    er = exp_rd();
    ei = exp_irq();
    vectors++;
    if (rdata !== er || irq !== ei) begin
      miscompares++;
      $display("FAIL %s: addr=%h rdata=%h expected %h, irq_req=%b expected %b",
               cur_tag, addr, rdata, er, irq, ei);
    end
  endtask

  task automatic cyc(input string tag, input logic [4:0] a, input logic w,
                     input logic [31:0] d);
    @(negedge clk);
    compare();
    cur_tag = tag;
    addr = a; we = w; wdata = d;
  endtask

  task automatic rd(input string tag, input logic [4:0] a);
    cyc(tag, a, 1'b0, 32'h0);
  endtask

  task automatic wr(input string tag, input logic [4:0] a, input logic [31:0] d);
    cyc(tag, a, 1'b1, d);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state on every register
    for (int k = 0; k < 8; k++) rd("R1 reset value", 5'(k * 4));

    // R2 edge source 5 pulses once, stays latched
    src = 8'h20; rd("R2 edge latch", 5'h00);
    src = 8'h00; rd("R2 edge sticky", 5'h00);
    rd("R2 edge sticky", 5'h00);
    src = 8'h20; rd("R2 held high no re-edge", 5'h00);
    wr("R4 ack edge", 5'h0C, 32'h20);
    rd("R2 held high after ack stays clear", 5'h00);
    src = 8'h00; rd("R2 idle", 5'h00);

    // R3 level source 1 held across acknowledge
    src = 8'h02; rd("R3 level set", 5'h00);
    wr("R3 ack while high", 5'h0C, 32'h02);
    rd("R3 re-set after ack", 5'h00);
    src = 8'h00; wr("R4 ack level low", 5'h0C, 32'h02);
    rd("R4 level cleared", 5'h00);

    // R4 edge arriving with its acknowledge is dropped
    src = 8'h40; wr("R4 ack beats edge", 5'h0C, 32'h40);
    src = 8'h00; rd("R4 ack beats edge", 5'h00);
    src = 8'h81; rd("R4 set two", 5'h00);
    src = 8'h01; wr("R4 all-ones ack", 5'h0C, 32'hFFFF_FFFF);
    rd("R4 all-ones ack level returns", 5'h00);

    // R5 whole-word enable load
    wr("R5 enable load", 5'h08, 32'hFFFF_FFFF);
    rd("R5 upper bits zero", 5'h08);
    wr("R5 enable zero", 5'h08, 32'h0);
    rd("R5 enable zero", 5'h08);
    // R6 / R7 alias registers
    wr("R6 set enable", 5'h10, 32'h0000_00A4);
    wr("R6 set more", 5'h10, 32'h0000_0001);
    rd("R6 read enable", 5'h08);
    rd("R11 setenable reads zero", 5'h10);
    wr("R7 clear enable", 5'h14, 32'h0000_0084);
    rd("R7 read enable", 5'h08);
    rd("R11 clrenable reads zero", 5'h14);

    // R8 / R9 pending and vector under several patterns
    src = 8'h00; wr("R4 clear all", 5'h0C, 32'hFF);
    wr("R5 enable all", 5'h08, 32'hFF);
    src = 8'h00; rd("R9 none pending", 5'h18);
    src = 8'h90; rd("R9 edges 4 and 7", 5'h18);
    src = 8'h00; rd("R8 pending", 5'h04);
    wr("R7 drop 4", 5'h14, 32'h10);
    rd("R9 vector 7", 5'h18);
    src = 8'h08; rd("R9 vector 3", 5'h18);
    src = 8'h00; rd("R8 pending mix", 5'h04);
    rd("R12 unaligned addr", 5'h1B);

    // R10 master control combinations
    wr("R10 master only", 5'h1C, 32'h1);
    rd("R10 master only", 5'h1C);
    wr("R10 hw only", 5'h1C, 32'h2);
    rd("R10 hw only", 5'h1C);
    wr("R10 both", 5'h1C, 32'hFFFF_FFFF);
    rd("R10 both irq high", 5'h1C);
    wr("R10 ack all drops irq", 5'h0C, 32'hFF);
    rd("R10 irq low", 5'h18);

    // R11 writes to read-only words
    src = 8'h04; rd("R11 prep", 5'h00);
    src = 8'h00; wr("R11 write status", 5'h00, 32'h0);
    wr("R11 write pending", 5'h04, 32'hFF);
    wr("R11 write vector", 5'h18, 32'h3);
    rd("R11 status kept", 5'h00);
    rd("R11 enable kept", 5'h08);
    rd("R11 master kept", 5'h1C);

    // R12 mixed random traffic and sources
    for (int k = 0; k < 4000; k++) begin
      src = 8'($urandom);
      if ($urandom_range(0, 2) == 0)
        wr("R12 random write", 5'($urandom), $urandom);
      else
        rd("R12 random read", 5'($urandom));
    end
    rd("R12 final", 5'h00);
    rd("R12 final", 5'h00);
    done = 1;
    finish_run();
  end
endmodule